// File: doc/BRIEF.md
# Bidirectional Readout Token Chain

This block sits in every chip of a daisy chain of readout chips and decides when the chip drives its own event data and when it only relays a neighbour's data. A direction input picks the side the chip reads toward. Each chip can start readout in one of two ways. As a master it starts on a read-event request. As a slave it starts only on the token arriving from the chosen side.

Once started, the chip shifts out a fixed-length local event one word per cycle. The event is supplied as a parallel frame by the storage next to the block. The chip then hands a one-cycle token to the neighbour on the far side. While the chip is not driving its own words, it relays the data arriving from the chosen side to its main output and to that side's output. All outputs are registered. A start with no local event pending sends the token on at once.

Top module: `token_chain_ro`

## Requirements
- R1: Reset (rst_n low, asynchronous) drives every data output, both token outputs and ev_taken to 0, and drops any readout in progress, so no word or token from it appears after release.
- R2: With resp_rd_en = 1, a rd_req while idle starts readout; tok_in_left and tok_in_right do not start it.
- R3: With resp_rd_en = 0 and dir_right = 0 (left), tok_in_left starts readout; tok_in_right and rd_req are ignored.
- R4: With resp_rd_en = 0 and dir_right = 1 (right), tok_in_right starts readout; tok_in_left and rd_req are ignored.
- R5: A start with ev_present = 1 puts the NWORDS words of ev_frame on data_out on consecutive cycles. Word 0 is bits [W-1:0] and appears on the clock edge that samples the start. Each word also appears on the output of the chosen side, and the other side's output stays 0.
- R6: Idle with dir_right = 0, pass_in_left appears on data_out and dout_left one cycle later; dout_right is 0.
- R7: Idle with dir_right = 1, pass_in_right appears on data_out and dout_right one cycle later; dout_left is 0.
- R8: While local words are being driven, pass-through data does not reach any output.
- R9: One cycle after the last local word, a token pulse exactly one cycle wide leaves on the far side: tok_out_right when dir_right = 0, tok_out_left when dir_right = 1.
- R10: A start with ev_present = 0 drives no local word and raises the far-side token on the edge that samples the start.
- R11: ev_taken is high for exactly the one cycle whose edge captured a start with ev_present = 1.
- R12: Start requests that arrive while a readout is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_right | input | 1 | Readout side: 0 left, 1 right |
| resp_rd_en | input | 1 | 1: master, reacts to rd_req; 0: slave, reacts to token |
| rd_req | input | 1 | Read-event request |
| tok_in_left | input | 1 | Token from left neighbour |
| tok_in_right | input | 1 | Token from right neighbour |
| pass_in_left | input | W | Data from left neighbour |
| pass_in_right | input | W | Data from right neighbour |
| ev_present | input | 1 | A local event is pending |
| ev_frame | input | NWORDS*W | Local event, word 0 in the low bits |
| ev_taken | output | 1 | Pulse: local event captured for readout |
| data_out | output | W | Main data output |
| dout_left | output | W | Data output toward left side |
| dout_right | output | W | Data output toward right side |
| tok_out_left | output | 1 | Token toward left neighbour |
| tok_out_right | output | 1 | Token toward right neighbour |

## Verification
A stuck or miscounted word index shows on data_out within one cycle of the start as a repeated, skipped or early-ended word. The far-side token also comes a cycle early or late. A wrong start decision shows on the very edge that samples the stray request: a local word replaces the relayed neighbour data, and ev_taken pulses. A side-select error shows one cycle after the direction is applied, as data on the wrong side output or a token leaving toward the wrong neighbour.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic {
        SIDE_LEFT  = 1'b0,
        SIDE_RIGHT = 1'b1
    } side_e;

    function automatic side_e far_side(input side_e s);
        return (s == SIDE_LEFT) ? SIDE_RIGHT : SIDE_LEFT;
    endfunction

endpackage

// File: rtl/rtc_start_sel.sv
module rtc_start_sel
    import rtc_pkg::*;
(
    input  logic idle,
    input  logic dir_right,
    input  logic resp_rd_en,
    input  logic rd_req,
    input  logic tok_in_left,
    input  logic tok_in_right,
    output logic start
);
    side_e side;
    logic  tok_sel;

    always_comb begin
        side    = side_e'(dir_right);
        tok_sel = (side == SIDE_RIGHT) ? tok_in_right : tok_in_left;
        if (!idle) begin
            start = 1'b0;
        end else if (resp_rd_en) begin
            start = rd_req;
        end else begin
            start = tok_sel;
        end
    end
endmodule

// File: rtl/rtc_side_mux.sv
module rtc_side_mux #(
    parameter int W = 4
) (
    input  logic         dir_right,
    input  logic [W-1:0] in_left,
    input  logic [W-1:0] in_right,
    output logic [W-1:0] sel
);
    always_comb begin
        sel = dir_right ? in_right : in_left;
    end
endmodule

// File: rtl/rtc_word_pick.sv
module rtc_word_pick #(
    parameter int W      = 4,
    parameter int NWORDS = 3,
    parameter int IW     = $clog2(NWORDS + 1)
) (
    input  logic [NWORDS*W-1:0] frame,
    input  logic [IW-1:0]       idx,
    output logic [W-1:0]        word
);
    logic [W-1:0] words [NWORDS];

    for (genvar g = 0; g < NWORDS; g++) begin : g_split
        assign words[g] = frame[g*W +: W];
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < NWORDS; i++) begin
            if (idx == IW'(i)) begin
                word = words[i];
            end
        end
    end
endmodule

// File: rtl/token_chain_ro.sv
module token_chain_ro
    import rtc_pkg::*;
#(
    parameter int W      = 4,
    parameter int NWORDS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_right,
    input  logic                resp_rd_en,
    input  logic                rd_req,
    input  logic                tok_in_left,
    input  logic                tok_in_right,
    input  logic [W-1:0]        pass_in_left,
    input  logic [W-1:0]        pass_in_right,
    input  logic                ev_present,
    input  logic [NWORDS*W-1:0] ev_frame,
    output logic                ev_taken,
    output logic [W-1:0]        data_out,
    output logic [W-1:0]        dout_left,
    output logic [W-1:0]        dout_right,
    output logic                tok_out_left,
    output logic                tok_out_right
);
    localparam int FW = NWORDS * W;
    localparam int IW = $clog2(NWORDS + 1);
    localparam logic [IW-1:0] LAST_IDX = IW'(NWORDS);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [FW-1:0] frame;
        logic [W-1:0]  dout;
        logic [W-1:0]  dl;
        logic [W-1:0]  dr;
        logic          tl;
        logic          tr;
        logic          tk;
    } st_t;

    st_t st_d, st_q;

    logic          busy_q;
    logic          start_w;
    logic [W-1:0]  pass_sel;
    logic [W-1:0]  word_w;
    logic [FW-1:0] frame_sel;
    logic [IW-1:0] idx_sel;
    logic [W-1:0]  out_w;
    side_e         far_w;

    assign busy_q    = st_q.busy;
    assign frame_sel = busy_q ? st_q.frame : ev_frame;
    assign idx_sel   = busy_q ? st_q.idx : '0;

    rtc_start_sel u_start (
        .idle         (!busy_q),
        .dir_right    (dir_right),
        .resp_rd_en   (resp_rd_en),
        .rd_req       (rd_req),
        .tok_in_left  (tok_in_left),
        .tok_in_right (tok_in_right),
        .start        (start_w)
    );

    rtc_side_mux #(.W(W)) u_pass (
        .dir_right (dir_right),
        .in_left   (pass_in_left),
        .in_right  (pass_in_right),
        .sel       (pass_sel)
    );

    rtc_word_pick #(.W(W), .NWORDS(NWORDS), .IW(IW)) u_pick (
        .frame (frame_sel),
        .idx   (idx_sel),
        .word  (word_w)
    );

    always_comb begin
        st_d    = st_q;
        st_d.tl = 1'b0;
        st_d.tr = 1'b0;
        st_d.tk = 1'b0;
        out_w   = pass_sel;
        far_w   = far_side(side_e'(dir_right));

        if (busy_q) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
                st_d.idx  = '0;
                if (far_w == SIDE_RIGHT) st_d.tr = 1'b1;
                else                     st_d.tl = 1'b1;
            end else begin
                out_w    = word_w;
                st_d.idx = st_q.idx + 1'b1;
            end
        end else if (start_w) begin
            if (ev_present) begin
                out_w      = word_w;
                st_d.frame = ev_frame;
                st_d.busy  = 1'b1;
                st_d.idx   = IW'(1);
                st_d.tk    = 1'b1;
            end else begin
                if (far_w == SIDE_RIGHT) st_d.tr = 1'b1;
                else                     st_d.tl = 1'b1;
            end
        end

        st_d.dout = out_w;
        st_d.dl   = dir_right ? '0 : out_w;
        st_d.dr   = dir_right ? out_w : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ev_taken      = st_q.tk;
    assign data_out      = st_q.dout;
    assign dout_left     = st_q.dl;
    assign dout_right    = st_q.dr;
    assign tok_out_left  = st_q.tl;
    assign tok_out_right = st_q.tr;
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         dir_right,
    input logic         busy_q,
    input logic         start_w,
    input logic [W-1:0] pass_in_left,
    input logic [W-1:0] data_out,
    input logic [W-1:0] dout_left,
    input logic [W-1:0] dout_right,
    input logic         tok_out_left,
    input logic         tok_out_right,
    input logic         ev_taken
);
    AST_TOK_ONE_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tok_out_left && tok_out_right)); // R9
    AST_TOK_PULSE_R: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out_right |=> !tok_out_right); // R9
    AST_TOK_PULSE_L: assert property (@(posedge clk) disable iff (!rst_n)
        tok_out_left |=> !tok_out_left); // R9
    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ev_taken |=> !ev_taken); // R11
    AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> !ev_taken); // R12
    AST_LEFT_QUIET_R: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_right |=> (dout_right == '0) && !tok_out_left); // R6
    AST_PASS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_right && !busy_q && !start_w) |=>
        (data_out == $past(pass_in_left)) && (dout_left == $past(pass_in_left))); // R6
endmodule

bind token_chain_ro rtc_chk #(.W(W)) u_rtc_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .dir_right     (dir_right),
    .busy_q        (busy_q),
    .start_w       (start_w),
    .pass_in_left  (pass_in_left),
    .data_out      (data_out),
    .dout_left     (dout_left),
    .dout_right    (dout_right),
    .tok_out_left  (tok_out_left),
    .tok_out_right (tok_out_right),
    .ev_taken      (ev_taken)
);

// File: tb/token_chain_ro_tb.sv
module token_chain_ro_tb;
    localparam int W  = 4;
    localparam int NW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dir_right = 1'b0, resp_rd_en = 1'b1, rd_req = 1'b0;
    logic tok_in_left = 1'b0, tok_in_right = 1'b0;
    logic [W-1:0] pass_in_left = '0, pass_in_right = '0;
    logic ev_present = 1'b0;
    logic [NW*W-1:0] ev_frame = 12'hCBA;
    logic ev_taken, tok_out_left, tok_out_right;
    logic [W-1:0] data_out, dout_left, dout_right;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] d, l, r;
        logic tl, tr, tk;
        string tag;
    } exp_t;

    exp_t q[$];

    always #2.5 clk = ~clk;

    token_chain_ro #(.W(W), .NWORDS(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .dir_right(dir_right), .resp_rd_en(resp_rd_en),
        .rd_req(rd_req), .tok_in_left(tok_in_left), .tok_in_right(tok_in_right),
        .pass_in_left(pass_in_left), .pass_in_right(pass_in_right),
        .ev_present(ev_present), .ev_frame(ev_frame), .ev_taken(ev_taken),
        .data_out(data_out), .dout_left(dout_left), .dout_right(dout_right),
        .tok_out_left(tok_out_left), .tok_out_right(tok_out_right)
    );

    task automatic compare(input exp_t e);
        n_cmp++;
        if (data_out !== e.d || dout_left !== e.l || dout_right !== e.r ||
            tok_out_left !== e.tl || tok_out_right !== e.tr || ev_taken !== e.tk) begin
            n_bad++;
            $display("FAIL %s: got d=%h l=%h r=%h tl=%b tr=%b tk=%b exp d=%h l=%h r=%h tl=%b tr=%b tk=%b",
                     e.tag, data_out, dout_left, dout_right, tok_out_left, tok_out_right, ev_taken,
                     e.d, e.l, e.r, e.tl, e.tr, e.tk);
        end
    endtask

    // monitor: pops expectations pushed one cycle earlier
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) compare(q.pop_front());
        end
    end

    // driver: one cycle of stimulus plus the expected registered result
    task automatic cyc(input logic dr, input logic rs, input logic rd, input logic tl,
                       input logic tr, input logic [W-1:0] pl, input logic [W-1:0] pr,
                       input logic evp, input logic [W-1:0] ed, input logic [W-1:0] el,
                       input logic [W-1:0] er, input logic etl, input logic etr,
                       input logic etk, input string tag);
        exp_t e;
        @(negedge clk);
        #1;
        dir_right = dr; resp_rd_en = rs; rd_req = rd;
        tok_in_left = tl; tok_in_right = tr;
        pass_in_left = pl; pass_in_right = pr; ev_present = evp;
        e.d = ed; e.l = el; e.r = er; e.tl = etl; e.tr = etr; e.tk = etk; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, got hung exp finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        exp_t z;
        z.d = '0; z.l = '0; z.r = '0; z.tl = 0; z.tr = 0; z.tk = 0; z.tag = "R1 reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(z);
        rst_n = 1'b1;

        // R6 idle pass from left
        cyc(0,1,0,0,0,4'h5,4'h9,0, 4'h5,4'h5,4'h0,0,0,0, "R6 pass left");
        cyc(0,1,0,0,0,4'h6,4'h9,0, 4'h6,4'h6,4'h0,0,0,0, "R6 pass left 2");
        // R7 idle pass from right
        cyc(1,1,0,0,0,4'h5,4'h9,0, 4'h9,4'h0,4'h9,0,0,0, "R7 pass right");
        // R2 master: tokens ignored
        cyc(0,1,0,1,1,4'h3,4'h9,1, 4'h3,4'h3,4'h0,0,0,0, "R2 tokens ignored");
        // R2/R5/R11 master start, words A B C
        cyc(0,1,1,0,0,4'h3,4'h9,1, 4'hA,4'hA,4'h0,0,0,1, "R5 word0 R11 take");
        cyc(0,1,1,1,0,4'h3,4'h9,1, 4'hB,4'hB,4'h0,0,0,0, "R12 R8 word1");
        cyc(0,1,1,0,0,4'h7,4'h9,1, 4'hC,4'hC,4'h0,0,0,0, "R8 word2");
        cyc(0,1,0,0,0,4'h7,4'h9,1, 4'h7,4'h7,4'h0,0,1,0, "R9 token right");
        cyc(0,1,0,0,0,4'h7,4'h9,1, 4'h7,4'h7,4'h0,0,0,0, "R9 token one cycle");
        // R10 start with no event, right direction -> left token at once
        cyc(1,1,1,0,0,4'h7,4'h2,0, 4'h2,4'h0,4'h2,1,0,0, "R10 empty start");
        cyc(1,1,0,0,0,4'h7,4'h2,0, 4'h2,4'h0,4'h2,0,0,0, "R10 idle after");
        // R3 slave left
        cyc(0,0,1,0,0,4'h1,4'h2,1, 4'h1,4'h1,4'h0,0,0,0, "R3 rd_req ignored");
        cyc(0,0,0,0,1,4'h1,4'h2,1, 4'h1,4'h1,4'h0,0,0,0, "R3 right token ignored");
        cyc(0,0,0,1,0,4'h1,4'h2,1, 4'hA,4'hA,4'h0,0,0,1, "R3 left token start");
        cyc(0,0,0,0,0,4'h1,4'h2,1, 4'hB,4'hB,4'h0,0,0,0, "R3 word1");
        cyc(0,0,0,0,0,4'h1,4'h2,1, 4'hC,4'hC,4'h0,0,0,0, "R3 word2");
        cyc(0,0,0,0,0,4'h1,4'h2,1, 4'h1,4'h1,4'h0,0,1,0, "R3 R9 token");
        // R4 slave right
        cyc(1,0,1,0,0,4'h1,4'h2,1, 4'h2,4'h0,4'h2,0,0,0, "R4 rd_req ignored");
        cyc(1,0,0,1,0,4'h1,4'h2,1, 4'h2,4'h0,4'h2,0,0,0, "R4 left token ignored");
        cyc(1,0,0,0,1,4'h1,4'h2,1, 4'hA,4'h0,4'hA,0,0,1, "R4 right token start");
        cyc(1,0,0,0,0,4'h1,4'h2,1, 4'hB,4'h0,4'hB,0,0,0, "R4 R5 word1");
        cyc(1,0,0,0,0,4'h1,4'h2,1, 4'hC,4'h0,4'hC,0,0,0, "R4 R5 word2");
        cyc(1,0,0,0,0,4'h1,4'h2,1, 4'h2,4'h0,4'h2,1,0,0, "R4 R9 token left");
        cyc(1,0,0,0,0,4'h1,4'h2,1, 4'h2,4'h0,4'h2,0,0,0, "R9 token dropped");
        // R1 reset in mid-readout
        cyc(0,1,1,0,0,4'h4,4'h2,1, 4'hA,4'hA,4'h0,0,0,1, "R1 pre start");
        cyc(0,1,0,0,0,4'h4,4'h2,1, 4'hB,4'hB,4'h0,0,0,0, "R1 pre word1");
        @(negedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        z.tag = "R1 async reset";
        compare(z);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(0,1,0,0,0,4'h4,4'h2,1, 4'h4,4'h4,4'h0,0,0,0, "R1 no word after");
        cyc(0,1,0,0,0,4'h4,4'h2,1, 4'h4,4'h4,4'h0,0,0,0, "R1 no token after");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule